// File: doc/BRIEF.md
# Line-Buffered SPI Console Packetizer

The block collects 8-bit text characters from a local valid/ready stream into a packet buffer whose first nine bytes are a fixed frame header. When a stored character is a line feed, or when the payload area is full, the block sends the framed packet out as a write-only SPI master. It drives a serial clock, an active-low chip select and a data line. While a packet is going out, no further characters are accepted.

The frame carries the following, in order:
- a write command byte;
- a reserved zero byte;
- a console sub-command;
- a four-byte signature, sent low byte first;
- a message-type byte;
- a length byte;
- the payload characters.

If the wrap input is set when a flush begins, three short console-enable packets are sent before the text packet and a short exit packet is sent after it. Bits change while the serial clock is low and are meant to be sampled on its rising edge. The serial clock period is a fixed multiple of the core clock, set by a parameter.

Top module: `spi_console_framer`

## Requirements
- R1: Every text packet begins with the nine bytes 0x11, 0x00, 0xC0, 0x40, 0x44, 0x36, 0x47, 0x05 and L. Byte 8 (L) is the payload length.
- R2: Accepted characters appear in arrival order from byte 9 onward. L equals the number of characters stored since the previous flush.
- R3: Accepting a line feed (0x0A) starts a flush. The line feed is kept as the last payload character.
- R4: Accepting the 55th payload character starts a flush even without a line feed. The length never exceeds 55.
- R5: A text packet is exactly 9+L bytes inside one chip-select low window. The next packet starts again with an empty payload.
- R6: Bytes are sent MSB first. MOSI changes only while SCLK is low and is stable while SCLK is high. After the eighth bit of each byte, SCLK and MOSI are both low.
- R7: Between consecutive rising SCLK edges within a byte there are exactly 2*(CLK_DIV+1) core cycles.
- R8: Chip select stays low for a whole packet. Between packets it stays high for at least 2*(CLK_DIV+1) core cycles. SCLK is low whenever chip select is high.
- R9: char_ready_o is low from the cycle after a flushing character is accepted until the last packet and its trailing gap are done, and in particular whenever chip select is low. No accepted character is lost.
- R10: With wrap_en_i high at the start of a flush, the block sends packets in this order, each in its own chip-select window:
  - 11 00 AA AA 00;
  - 11 00 55 55 00;
  - 11 00 AA AA 00;
  - the text packet;
  - 11 00 E0 00.

  With wrap_en_i low, only the text packet is sent.
- R11: During and just after reset, chip select is high, SCLK and MOSI are low, and char_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| char_i | input | 8 | Character to append |
| char_valid_i | input | 1 | char_i holds a character |
| char_ready_o | output | 1 | Character is accepted on a clock edge where valid and ready are both high |
| wrap_en_i | input | 1 | Add enable and exit packets around the next flush |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data out |

## Verification
Single-character lines and short lines check the header and the length byte at small lengths. A run of exactly 55 characters without a line feed exercises the full-buffer flush and shows it apart from the newline flush. A 54-character line ended by a line feed checks that a line feed landing in the last slot causes one flush, not two. Random lines of 1 to 70 printable characters, with random idle gaps and back-to-back streaming, cover splitting across several packets, the held-off input and the optional enable and exit packets.

// File: rtl/spi_console_pkg.sv
package spi_console_pkg;
  localparam int HDR_BYTES = 9;
  localparam logic [7:0]  WR_CMD   = 8'h11;
  localparam logic [7:0]  SUB_WR   = 8'hC0;
  localparam logic [7:0]  SUB_EXIT = 8'hE0;
  localparam logic [31:0] SIG_WORD = 32'h4736_4440;
  localparam logic [7:0]  MSG_STR  = 8'h05;
  localparam logic [7:0]  LINE_END = 8'h0A;

  typedef enum logic [2:0] {PK_EN0, PK_EN1, PK_EN2, PK_MAIN, PK_EXIT} pkt_e;
  typedef enum logic [1:0] {SQ_FILL, SQ_SEND, SQ_WAIT, SQ_GAP} seq_e;

  function automatic logic [7:0] hdr_byte(input logic [3:0] i, input logic [7:0] len);
    case (i)
      4'd0:    return WR_CMD;
      4'd1:    return 8'h00;
      4'd2:    return SUB_WR;
      4'd3:    return SIG_WORD[7:0];
      4'd4:    return SIG_WORD[15:8];
      4'd5:    return SIG_WORD[23:16];
      4'd6:    return SIG_WORD[31:24];
      4'd7:    return MSG_STR;
      default: return len;
    endcase
  endfunction

  // enable/exit control packets
  function automatic logic [7:0] ctl_byte(input pkt_e p, input logic [2:0] i);
    logic [7:0] key;
    key = (p == PK_EN1) ? 8'h55 : 8'hAA;
    case (i)
      3'd0:    return WR_CMD;
      3'd1:    return 8'h00;
      3'd2:    return (p == PK_EXIT) ? SUB_EXIT : key;
      3'd3:    return (p == PK_EXIT) ? 8'h00 : key;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spi_console_buf.sv
module spi_console_buf
  import spi_console_pkg::*;
#(
  parameter int MAX_LEN = 55,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = $clog2(MAX_LEN + HDR_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [LEN_W-1:0] len_o,
  output logic [7:0]       rd_byte_o
);
  localparam int PAY_W = $clog2(MAX_LEN);

  logic [7:0]       mem_q [MAX_LEN];
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] pay_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (clr_i)   len_q <= '0;
    else if (wr_en_i) len_q <= len_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[len_q[PAY_W-1:0]] <= wr_data_i;
  end

  assign pay_idx = rd_idx_i - IDX_W'(HDR_BYTES);

  always_comb begin
    if (rd_idx_i < IDX_W'(HDR_BYTES)) rd_byte_o = hdr_byte(rd_idx_i[3:0], 8'(len_q));
    else                             rd_byte_o = mem_q[pay_idx[PAY_W-1:0]];
  end

  assign len_o = len_q;
endmodule

// File: rtl/spi_console_shift.sv
module spi_console_shift #(
  parameter int CLK_DIV = 1,
  parameter int DIV_W   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int HALVES = 17; // 16 bit halves plus one quiet tail
  localparam int HALF_W = $clog2(HALVES);

  logic              busy_q;
  logic [6:0]        sh_q;
  logic [HALF_W-1:0] half_q;
  logic [DIV_W-1:0]  div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_o <= 1'b0; sclk_o <= 1'b0; mosi_o <= 1'b0;
      sh_q <= '0; half_q <= '0; div_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        sh_q   <= byte_i[6:0];
        half_q <= '0;
        div_q  <= '0;
        sclk_o <= 1'b0;
        mosi_o <= byte_i[7];
      end else if (busy_q) begin
        if (div_q == DIV_W'(CLK_DIV)) begin
          div_q  <= '0;
          half_q <= half_q + 1'b1;
          if (half_q == HALF_W'(HALVES - 1)) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else if (half_q == HALF_W'(HALVES - 2)) begin
            sclk_o <= 1'b0;
            mosi_o <= 1'b0;
          end else if (!half_q[0]) begin
            sclk_o <= 1'b1;
          end else begin
            sclk_o <= 1'b0;
            mosi_o <= sh_q[6];
            sh_q   <= {sh_q[5:0], 1'b0};
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_console_seq.sv
module spi_console_seq
  import spi_console_pkg::*;
#(
  parameter int CLK_DIV = 1,
  parameter int LEN_W   = 6,
  parameter int IDX_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wrap_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             done_i,
  output logic             ready_o,
  output logic             start_o,
  output pkt_e             pkt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cs_no,
  output logic             clr_o
);
  localparam int GAP_CYC = 2 * (CLK_DIV + 1);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  seq_e             st_q;
  pkt_e             pkt_q;
  logic [IDX_W-1:0] idx_q;
  logic [GAP_W-1:0] gap_q;
  logic             wrap_q;
  logic [IDX_W:0]   pkt_len;
  logic             last_byte;

  always_comb begin
    case (pkt_q)
      PK_MAIN: pkt_len = (IDX_W+1)'(HDR_BYTES) + (IDX_W+1)'(len_i);
      PK_EXIT: pkt_len = (IDX_W+1)'(4);
      default: pkt_len = (IDX_W+1)'(5);
    endcase
  end

  assign last_byte = ({1'b0, idx_q} == pkt_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_FILL; pkt_q <= PK_MAIN; idx_q <= '0; gap_q <= '0; wrap_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_FILL: if (flush_i) begin
          wrap_q <= wrap_i;
          pkt_q  <= wrap_i ? PK_EN0 : PK_MAIN;
          idx_q  <= '0;
          st_q   <= SQ_SEND;
        end
        SQ_SEND: st_q <= SQ_WAIT;
        SQ_WAIT: if (done_i) begin
          if (last_byte) begin
            st_q  <= SQ_GAP;
            gap_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= SQ_SEND;
          end
        end
        default: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            idx_q <= '0;
            st_q  <= SQ_SEND;
            case (pkt_q)
              PK_EN0:  pkt_q <= PK_EN1;
              PK_EN1:  pkt_q <= PK_EN2;
              PK_EN2:  pkt_q <= PK_MAIN;
              PK_MAIN: if (wrap_q) pkt_q <= PK_EXIT; else st_q <= SQ_FILL;
              default: st_q <= SQ_FILL;
            endcase
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign ready_o = (st_q == SQ_FILL);
  assign start_o = (st_q == SQ_SEND);
  assign cs_no   = !((st_q == SQ_SEND) || (st_q == SQ_WAIT));
  assign clr_o   = (st_q == SQ_WAIT) && done_i && last_byte && (pkt_q == PK_MAIN);
  assign pkt_o   = pkt_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/spi_console_framer.sv
module spi_console_framer
  import spi_console_pkg::*;
#(
  parameter int CLK_DIV   = 1,
  parameter int PKT_BYTES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] char_i,
  input  logic       char_valid_i,
  output logic       char_ready_o,
  input  logic       wrap_en_i,
  output logic       spi_sclk_o,
  output logic       spi_cs_no,
  output logic       spi_mosi_o
);
  localparam int MAX_LEN = PKT_BYTES - HDR_BYTES;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(PKT_BYTES);

  logic             accept, flush, clr, start, done;
  logic [LEN_W-1:0] buf_len;
  logic [IDX_W-1:0] idx;
  logic [7:0]       buf_byte, tx_byte;
  pkt_e             pkt;

  assign accept = char_valid_i && char_ready_o;
  assign flush  = accept && ((char_i == LINE_END) || (buf_len == LEN_W'(MAX_LEN - 1)));

  spi_console_buf #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni, .wr_en_i(accept), .wr_data_i(char_i), .clr_i(clr),
    .rd_idx_i(idx), .len_o(buf_len), .rd_byte_o(buf_byte)
  );

  spi_console_seq #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .flush_i(flush), .wrap_i(wrap_en_i), .len_i(buf_len),
    .done_i(done), .ready_o(char_ready_o), .start_o(start), .pkt_o(pkt),
    .idx_o(idx), .cs_no(spi_cs_no), .clr_o(clr)
  );

  assign tx_byte = (pkt == PK_MAIN) ? buf_byte : ctl_byte(pkt, idx[2:0]);

  spi_console_shift #(.CLK_DIV(CLK_DIV), .DIV_W(4)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .byte_i(tx_byte), .done_o(done),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o)
  );
endmodule

// File: rtl/spi_console_chk.sv
module spi_console_chk #(
  parameter int MAX_LEN = 55,
  parameter int LEN_W   = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_i,
  input logic             cs_ni,
  input logic             sclk_i,
  input logic             mosi_i,
  input logic [LEN_W-1:0] len_i
);
  AST_CS_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_ni |-> !ready_i); // R9
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) cs_ni |-> !sclk_i); // R8
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) sclk_i |-> $stable(mosi_i)); // R6
  AST_CS_ENDS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(cs_ni) |-> (!sclk_i && !mosi_i)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) len_i <= LEN_W'(MAX_LEN)); // R4
endmodule

bind spi_console_framer spi_console_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(char_ready_o), .cs_ni(spi_cs_no),
  .sclk_i(spi_sclk_o), .mosi_i(spi_mosi_o), .len_i(buf_len)
);

// File: tb/spi_console_framer_test.sv
module spi_console_framer_test;
  localparam int DIV = 1;
  localparam int PER = 2 * (DIV + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] char_d = 8'h00;
  logic valid = 1'b0, wrap = 1'b0;
  logic ready, sclk, cs_n, mosi;

  always #2 clk = ~clk;

  spi_console_framer #(.CLK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .char_i(char_d), .char_valid_i(valid),
    .char_ready_o(ready), .wrap_en_i(wrap), .spi_sclk_o(sclk), .spi_cs_no(cs_n),
    .spi_mosi_o(mosi)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  int explen_q[$];
  logic [7:0] mbuf[$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_ctl(logic [7:0] a, logic [7:0] b, logic [7:0] c, int n);
    exp_q.push_back(8'h11); exp_q.push_back(8'h00); exp_q.push_back(a); exp_q.push_back(b);
    if (n == 5) exp_q.push_back(c);
    repeat (n) tag_q.push_back("R10");
    explen_q.push_back(n);
  endtask

  task automatic emit(bit w);
    logic [7:0] hdr[8] = '{8'h11, 8'h00, 8'hC0, 8'h40, 8'h44, 8'h36, 8'h47, 8'h05};
    string ltag;
    ltag = (mbuf[mbuf.size()-1] == 8'h0A) ? "R3" : "R4";
    if (w) begin
      push_ctl(8'hAA, 8'hAA, 8'h00, 5);
      push_ctl(8'h55, 8'h55, 8'h00, 5);
      push_ctl(8'hAA, 8'hAA, 8'h00, 5);
    end
    for (int i = 0; i < 8; i++) begin exp_q.push_back(hdr[i]); tag_q.push_back("R1"); end
    exp_q.push_back(8'(mbuf.size())); tag_q.push_back(ltag);
    foreach (mbuf[i]) begin exp_q.push_back(mbuf[i]); tag_q.push_back("R2"); end
    explen_q.push_back(9 + mbuf.size());
    if (w) push_ctl(8'hE0, 8'h00, 8'h00, 4);
    mbuf.delete();
  endtask

  task automatic send_char(logic [7:0] c);
    valid = 1'b1; char_d = c;
    while (!ready) @(negedge clk);
    mbuf.push_back(c);
    if (c == 8'h0A || mbuf.size() == 55) emit(wrap);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !cs_n || !ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // SPI monitor
  logic p_sclk = 0, p_cs = 1, p_mosi = 0, tail = 0, seen_pkt = 0;
  logic [7:0] shr = 0;
  int bitcnt = 0, nbytes = 0, last_rise = 0, cs_rise_cyc = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_cs && !cs_n) begin
        if (seen_pkt) check(cyc - cs_rise_cyc >= PER, "R8", cyc - cs_rise_cyc, PER);
        check(!ready, "R9", ready, 0);
        bitcnt = 0; nbytes = 0;
      end
      if (!p_sclk && sclk) begin
        if (cs_n) check(0, "R8", sclk, 0);
        check(mosi == p_mosi, "R6", mosi, p_mosi);
        if (bitcnt > 0) check(cyc - last_rise == PER, "R7", cyc - last_rise, PER);
        last_rise = cyc;
        shr = {shr[6:0], mosi};
        bitcnt++;
        if (bitcnt == 8) begin
          if (exp_q.size() == 0) check(0, "R5", shr, 0);
          else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(shr == e, t, shr, e);
          end
          nbytes++; bitcnt = 0; tail = 1;
        end
      end
      if (p_sclk && !sclk && tail) begin
        check(!mosi, "R6", mosi, 0);
        tail = 0;
      end
      if (!p_cs && cs_n) begin
        check(!sclk && bitcnt == 0, "R8", bitcnt, 0);
        if (explen_q.size() == 0) check(0, "R5", nbytes, 0);
        else begin
          automatic int el = explen_q.pop_front();
          check(nbytes == el, "R5", nbytes, el);
        end
        cs_rise_cyc = cyc; seen_pkt = 1;
      end
    end
    p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5719));
    repeat (4) @(negedge clk);
    check(cs_n && !sclk && !mosi && ready, "R11", {cs_n, sclk, mosi, ready}, 4'b1001);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cs_n && !sclk && !mosi && ready, "R11", {cs_n, sclk, mosi, ready}, 4'b1001);

    send_char(8'h0A); drain();                                    // R3 lone line feed
    send_char("H"); send_char("i"); send_char(8'h0A); drain();
    for (int i = 0; i < 55; i++) send_char(8'(8'h41 + i % 26));   // R4 full flush
    drain();
    for (int i = 0; i < 54; i++) send_char(8'(8'h61 + i % 26));
    send_char(8'h0A); drain();                                    // line feed in last slot
    check(explen_q.size() == 0, "R5", explen_q.size(), 0);
    wrap = 1'b1;                                                  // R10
    send_char("o"); send_char("k"); send_char(8'h0A); drain();
    wrap = 1'b0;

    for (int l = 0; l < 15; l++) begin
      automatic int n = $urandom_range(1, 70);
      wrap = ($urandom_range(0, 3) == 0);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 2) == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
        send_char(8'($urandom_range(8'h20, 8'h7E)));
      end
      if ($urandom_range(0, 3) != 0) send_char(8'h0A);
      else if (mbuf.size() != 0) send_char(8'h0A);
      drain();
    end
    check(exp_q.size() == 0 && explen_q.size() == 0, "R9", exp_q.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule